// File: doc/BRIEF.md
# Output Fault Qualifier and Latch

This block sits between the raw fault comparators of a bank of power output drivers and the status-read logic. It takes one raw over-temperature and one raw open-load signal per output, one raw over-current signal per low-side output, and a single raw over-voltage signal for the whole device. It qualifies each one against the output's on/off state and a per-channel open-load enable. It then holds every qualified fault in a flag until the status reader clears it.

Outputs split into `N_HS` high-side channels (indices `0..N_HS-1`) and `N_LS` low-side channels (indices `N_HS..N_HS+N_LS-1`). On low-side channels a noise filter qualifies over-current and open load. The filter counts consecutive clock edges on which the fault is present in its qualifying output state. Over-temperature, high-side open load and over-voltage latch on the first edge on which they are seen.

A single clear strobe acts on every flag at once. A flag is released only if its condition has gone away. All raw inputs are assumed to be synchronous to `clk_i`.

Top module: `out_fault_qual`

## Requirements
- R1: While `rst_ni` is low, and after reset is released, every fault flag and `any_fault_o` read 0. `ol_en_o` reads 1 on the `N_HS` high-side bits and 0 on the low-side bits (`12'h00F` with defaults).
- R2: An over-temperature flag sets after the first rising edge on which its raw input is 1, whatever the output state. This holds on both high-side and low-side channels.
- R3: A low-side over-current flag `oc_flag_o[j]` sets after the rising edge on which `oc_raw_i[j]` and `on_i[N_HS+j]` have both been 1 for `dly_i` consecutive edges, and not one edge earlier.
- R4: A low-side over-current is ignored while its output is off. The filter count restarts whenever the qualifying condition drops for one edge.
- R5: A low-side open-load flag qualifies only while its output is off and its open-load enable is 1. It sets after `dly_i` consecutive qualifying edges, and raw open load is ignored while the output is on.
- R6: A high-side open-load flag sets after the first edge on which its raw input is 1 and its enable is 1, regardless of the output state. It is ignored while its enable is 0.
- R7: A 1 on `ol_en_wr_i` loads `ol_en_d_i` into the per-channel open-load enables at that edge. Open load on a disabled channel never sets a flag.
- R8: The over-voltage flag is global. It sets after the first edge with `ov_raw_i` at 1.
- R9: A set flag holds without a clear. On an edge with `clr_i` at 1, a flag is released only if its qualified condition is absent on that edge, and is otherwise kept.
- R10: When a fault is set on the same edge as a clear, the flag is set.
- R11: `any_fault_o` is 1 exactly when any per-channel flag or the over-voltage flag is 1.
- R12: A `dly_i` of 0 behaves as 1: the filtered fault sets after the first qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| on_i | input | N_HS+N_LS | Output on state per channel |
| ot_raw_i | input | N_HS+N_LS | Raw over-temperature per channel |
| ol_raw_i | input | N_HS+N_LS | Raw open load per channel |
| oc_raw_i | input | N_LS | Raw over-current per low-side channel |
| ov_raw_i | input | 1 | Raw global over-voltage |
| dly_i | input | DLY_W | Low-side filter delay in clock edges |
| ol_en_wr_i | input | 1 | Load strobe for the open-load enables |
| ol_en_d_i | input | N_HS+N_LS | New open-load enable values |
| clr_i | input | 1 | Clear strobe from the status read |
| ol_en_o | output | N_HS+N_LS | Current open-load enables |
| ot_flag_o | output | N_HS+N_LS | Latched over-temperature flags |
| ol_flag_o | output | N_HS+N_LS | Latched open-load flags |
| oc_flag_o | output | N_LS | Latched low-side over-current flags |
| ov_flag_o | output | 1 | Latched global over-voltage flag |
| any_fault_o | output | 1 | OR of all latched flags |

## Verification
The clear strobe and the setting of a fault can land on the same rising edge. The result must depend on whether the condition is still present on that edge. The bench pulses `clr_i` while a fresh over-temperature rises, expecting the flag to set. It also pulses it while an already latched over-temperature and a latched low-side over-current are still raw, expecting both flags to be kept. Each outcome is read at the flag ports on the falling edge after that rising edge.

// File: rtl/fq_pkg.sv
package fq_pkg;
  function automatic int unsigned ch_count(input int unsigned n_hs, input int unsigned n_ls);
    return n_hs + n_ls;
  endfunction
endpackage

// File: rtl/fq_cell.sv
module fq_cell #(
  parameter bit FILT  = 1'b1,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cond_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic set_w;

  generate
    if (FILT) begin : g_filt
      localparam logic [DLY_W-1:0] CNT_MAX = '1;
      logic [DLY_W-1:0] cnt_q;
      logic [DLY_W:0]   cnt_nxt;
      logic [DLY_W:0]   dly_eff;

      assign dly_eff = (dly_i == '0) ? {{DLY_W{1'b0}}, 1'b1} : {1'b0, dly_i};
      assign cnt_nxt = {1'b0, cnt_q} + {{DLY_W{1'b0}}, 1'b1};
      assign set_w   = cond_i && (cnt_nxt >= dly_eff);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (!cond_i)       cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_nxt[DLY_W-1:0];
      end

      // count restarts after a gap
      p_cnt_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cond_i |=> (cnt_q == '0));
      // count never moves backwards while the condition holds
      p_cnt_mono_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i && $past(cond_i)) |-> (cnt_q >= $past(cnt_q)));
    end else begin : g_direct
      logic unused_dly;
      assign unused_dly = ^dly_i;
      assign set_w      = cond_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_o <= 1'b0;
    else if (set_w)             flag_o <= 1'b1;
    else if (clr_i && !cond_i)  flag_o <= 1'b0;
  end

  p_rise_needs_cond_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(cond_i));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && (!clr_i || cond_i)) |=> flag_o);
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && clr_i && !cond_i) |=> !flag_o);
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_w && clr_i) |=> flag_o);
endmodule

// File: rtl/fq_olen_reg.sv
module fq_olen_reg #(
  parameter int N_HS = 4,
  parameter int N_LS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [N_HS+N_LS-1:0] d_i,
  output logic [N_HS+N_LS-1:0] en_o
);
  localparam logic [N_HS+N_LS-1:0] EN_RST = {{N_LS{1'b0}}, {N_HS{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= EN_RST;
    else if (wr_i) en_o <= d_i;
  end

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_o == $past(d_i)));
  p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/out_fault_qual.sv
module out_fault_qual #(
  parameter int N_HS  = 4,
  parameter int N_LS  = 8,
  parameter int DLY_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_HS+N_LS-1:0] on_i,
  input  logic [N_HS+N_LS-1:0] ot_raw_i,
  input  logic [N_HS+N_LS-1:0] ol_raw_i,
  input  logic [N_LS-1:0]      oc_raw_i,
  input  logic                 ov_raw_i,
  input  logic [DLY_W-1:0]     dly_i,
  input  logic                 ol_en_wr_i,
  input  logic [N_HS+N_LS-1:0] ol_en_d_i,
  input  logic                 clr_i,
  output logic [N_HS+N_LS-1:0] ol_en_o,
  output logic [N_HS+N_LS-1:0] ot_flag_o,
  output logic [N_HS+N_LS-1:0] ol_flag_o,
  output logic [N_LS-1:0]      oc_flag_o,
  output logic                 ov_flag_o,
  output logic                 any_fault_o
);
  import fq_pkg::*;
  localparam int N_CH = ch_count(N_HS, N_LS);

  fq_olen_reg #(.N_HS(N_HS), .N_LS(N_LS)) u_olen (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ol_en_wr_i), .d_i(ol_en_d_i), .en_o(ol_en_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ot
    fq_cell #(.FILT(1'b0), .DLY_W(DLY_W)) u_ot (
      .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(ot_raw_i[c]), .dly_i(dly_i),
      .clr_i(clr_i), .flag_o(ot_flag_o[c])
    );
  end

  for (genvar h = 0; h < N_HS; h++) begin : g_hs
    logic ol_cond;
    assign ol_cond = ol_raw_i[h] && ol_en_o[h];
    fq_cell #(.FILT(1'b0), .DLY_W(DLY_W)) u_ol (
      .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(ol_cond), .dly_i(dly_i),
      .clr_i(clr_i), .flag_o(ol_flag_o[h])
    );
  end

  for (genvar j = 0; j < N_LS; j++) begin : g_ls
    localparam int CH = N_HS + j;
    logic ol_cond, oc_cond;
    assign ol_cond = ol_raw_i[CH] && ol_en_o[CH] && !on_i[CH];
    assign oc_cond = oc_raw_i[j] && on_i[CH];

    fq_cell #(.FILT(1'b1), .DLY_W(DLY_W)) u_ol (
      .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(ol_cond), .dly_i(dly_i),
      .clr_i(clr_i), .flag_o(ol_flag_o[CH])
    );
    fq_cell #(.FILT(1'b1), .DLY_W(DLY_W)) u_oc (
      .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(oc_cond), .dly_i(dly_i),
      .clr_i(clr_i), .flag_o(oc_flag_o[j])
    );

    p_oc_off_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!on_i[CH] && !oc_flag_o[j]) |=> !oc_flag_o[j]);
    p_ol_on_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (on_i[CH] && !ol_flag_o[CH]) |=> !ol_flag_o[CH]);
  end

  fq_cell #(.FILT(1'b0), .DLY_W(DLY_W)) u_ov (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(ov_raw_i), .dly_i(dly_i),
    .clr_i(clr_i), .flag_o(ov_flag_o)
  );

  assign any_fault_o = (|ot_flag_o) | (|ol_flag_o) | (|oc_flag_o) | ov_flag_o;

  p_ov_in_summary_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_flag_o |-> any_fault_o);
  p_ot_in_summary_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_flag_o != '0) |-> any_fault_o);
  p_reset_clean_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !any_fault_o);
endmodule

// File: tb/out_fault_qual_tb_top.sv
module out_fault_qual_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_HS = 4;
  localparam int N_LS = 8;
  localparam int N_CH = N_HS + N_LS;
  localparam int DLY_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_CH-1:0] on_i = '0, ot_raw_i = '0, ol_raw_i = '0, ol_en_d_i = '0;
  logic [N_LS-1:0] oc_raw_i = '0;
  logic ov_raw_i = 1'b0, ol_en_wr_i = 1'b0, clr_i = 1'b0;
  logic [DLY_W-1:0] dly_i = 8'd4;
  logic [N_CH-1:0] ol_en_o, ot_flag_o, ol_flag_o;
  logic [N_LS-1:0] oc_flag_o;
  logic ov_flag_o, any_fault_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  out_fault_qual #(.N_HS(N_HS), .N_LS(N_LS), .DLY_W(DLY_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .on_i(on_i), .ot_raw_i(ot_raw_i), .ol_raw_i(ol_raw_i),
    .oc_raw_i(oc_raw_i), .ov_raw_i(ov_raw_i), .dly_i(dly_i), .ol_en_wr_i(ol_en_wr_i),
    .ol_en_d_i(ol_en_d_i), .clr_i(clr_i), .ol_en_o(ol_en_o), .ot_flag_o(ot_flag_o),
    .ol_flag_o(ol_flag_o), .oc_flag_o(oc_flag_o), .ov_flag_o(ov_flag_o),
    .any_fault_o(any_fault_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs change on falling edges; outputs are read on falling edges
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic clear_all();
    on_i = '0; ot_raw_i = '0; ol_raw_i = '0; oc_raw_i = '0; ov_raw_i = 1'b0;
    clr_i = 1'b1; step(); clr_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 any in reset", any_fault_o, 0);
    rst_ni = 1'b1; step(2);
    chk("R1 ot flags", ot_flag_o, 0);
    chk("R1 ol flags", ol_flag_o, 0);
    chk("R1 oc flags", oc_flag_o, 0);
    chk("R1 ov flag", ov_flag_o, 0);
    chk("R1 ol enables", ol_en_o, 32'h00F);
  endtask

  task automatic t_ot();
    ot_raw_i[5] = 1'b1; step(); ot_raw_i[5] = 1'b0;
    chk("R2 ot low-side ch5", ot_flag_o, 32'h020);
    chk("R11 any from ot", any_fault_o, 1);
    ot_raw_i[1] = 1'b1; on_i[1] = 1'b1; step(); ot_raw_i[1] = 1'b0;
    chk("R2 ot high-side ch1", ot_flag_o, 32'h022);
    clear_all();
    chk("R9 ot released", ot_flag_o, 0);
    chk("R11 any cleared", any_fault_o, 0);
  endtask

  task automatic t_oc_filter();
    on_i[4] = 1'b1; oc_raw_i[0] = 1'b1;
    step(3);
    chk("R3 oc not before delay", oc_flag_o, 0);
    step();
    chk("R3 oc at delay", oc_flag_o, 32'h01);
    clear_all();
    chk("R9 oc released", oc_flag_o, 0);
  endtask

  task automatic t_oc_gap_off();
    on_i[5] = 1'b1; oc_raw_i[1] = 1'b1; step(3);
    oc_raw_i[1] = 1'b0; step();
    oc_raw_i[1] = 1'b1; step(3);
    chk("R4 gap restarts count", oc_flag_o, 0);
    step();
    chk("R4 oc after fresh run", oc_flag_o, 32'h02);
    clear_all();
    on_i[6] = 1'b0; oc_raw_i[2] = 1'b1; step(6);
    chk("R4 oc ignored while off", oc_flag_o, 0);
    clear_all();
  endtask

  task automatic t_ol_ls();
    ol_raw_i[6] = 1'b1; step(6);
    chk("R7 ls ol disabled by default", ol_flag_o, 0);
    ol_en_d_i = 12'hFFB; ol_en_wr_i = 1'b1; step(); ol_en_wr_i = 1'b0;
    chk("R7 enable load", ol_en_o, 32'hFFB);
    step(3);
    chk("R5 ls ol not before delay", ol_flag_o, 0);
    step();
    chk("R5 ls ol at delay", ol_flag_o, 32'h040);
    clear_all();
    on_i[7] = 1'b1; ol_raw_i[7] = 1'b1; step(6);
    chk("R5 ls ol ignored while on", ol_flag_o, 0);
    clear_all();
  endtask

  task automatic t_ol_hs();
    on_i[1] = 1'b1; ol_raw_i[1] = 1'b1; step();
    chk("R6 hs ol immediate while on", ol_flag_o, 32'h002);
    ol_raw_i[2] = 1'b1; step(3);
    chk("R6 hs ol disabled ch2", ol_flag_o, 32'h002);
    clear_all();
    chk("R9 hs ol released", ol_flag_o, 0);
  endtask

  task automatic t_ov();
    ov_raw_i = 1'b1; step(); ov_raw_i = 1'b0;
    chk("R8 ov set", ov_flag_o, 1);
    chk("R11 any from ov", any_fault_o, 1);
    step(3);
    chk("R9 ov held without clear", ov_flag_o, 1);
    clr_i = 1'b1; step(); clr_i = 1'b0;
    chk("R9 ov released", ov_flag_o, 0);
  endtask

  task automatic t_clear_race();
    ot_raw_i[0] = 1'b1; step();
    clr_i = 1'b1; step(); clr_i = 1'b0;
    chk("R9 clear with raw present", ot_flag_o, 32'h001);
    ot_raw_i[0] = 1'b0;
    clr_i = 1'b1; ot_raw_i[3] = 1'b1; step(); clr_i = 1'b0;
    chk("R10 set beats clear", ot_flag_o, 32'h008);
    clear_all();
    on_i[11] = 1'b1; oc_raw_i[7] = 1'b1; step(4);
    chk("R3 oc ch11", oc_flag_o, 32'h80);
    clr_i = 1'b1; step(); clr_i = 1'b0;
    chk("R9 filtered flag kept", oc_flag_o, 32'h80);
    clear_all();
    chk("R11 all clear", any_fault_o, 0);
  endtask

  task automatic t_dly_zero();
    dly_i = '0;
    on_i[8] = 1'b1; oc_raw_i[4] = 1'b1; step();
    chk("R12 zero delay acts as one", oc_flag_o, 32'h10);
    clear_all();
    dly_i = 8'd4;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_ot();
    t_oc_filter();
    t_oc_gap_off();
    t_ol_ls();
    t_ol_hs();
    t_ov();
    t_clear_race();
    t_dly_zero();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule